// File: doc/BRIEF.md
# Window Watchdog and Reset Generator

This block supervises a microcontroller. It drives the controller's active-low reset line from two sources. The first is a power-on delay that starts once the supply-good input is high. The second is a window watchdog. When the power-on delay ends, the watchdog gives the software a lead time in which to deliver its first trigger. From then on, every accepted trigger starts a closed window, and an open window follows it. The next trigger must arrive inside the open window. A trigger that comes while the closed window is still running counts as a fault. So does a trigger that never comes. Either fault produces a reset pulse of fixed length, and after the pulse the block goes back to the lead-time phase.

A trigger is a falling edge on the active-low trigger pin or a rising edge on the active-high trigger pin. Both pins pass through a two-flop synchronizer before edge detection. All times are parameters counted in ticks of a slow timebase strobe. With a 0.5 ms tick, the defaults give:

| Interval | Ticks | Time |
|---|---|---|
| Power-on hold | 20 | 10 ms |
| Lead time | 98 | 49 ms |
| Closed window | 20 | 10 ms |
| Open window | 21 | 10.5 ms |
| Reset pulse | 4 | about 2 ms |

A disable input or a low-power-mode input switches the watchdog off. Loss of supply at any time pulls reset low again.

Top module: `wdt_supervisor`

## Requirements
- R1: While `supply_ok` is low, `rst_out_n` is low from the clock edge after `supply_ok` is sampled low onward.
- R2: After `supply_ok` goes high, `rst_out_n` stays low for `POR_TICKS` ticks and rises on the clock edge that counts the last of them.
- R3: After reset is released, if no trigger arrives within `LEAD_TICKS` ticks, a reset pulse starts on the edge that counts the last tick.
- R4: An accepted trigger starts a closed window of `SHUT_TICKS` ticks. A trigger inside the closed window starts a reset pulse on the edge where it acts.
- R5: After the closed window, an open window of `OPEN_TICKS` ticks runs. A trigger there is accepted, keeps reset high and starts a new closed window. If the open window expires with no trigger, a reset pulse starts.
- R6: A watchdog reset pulse holds `rst_out_n` low for `PULSE_TICKS` ticks. The block then releases reset and re-enters the lead-time phase. Triggers during the pulse are ignored.
- R7: A trigger is a falling edge on `trig_n` or a rising edge on `trig_p`. A rising edge on `trig_n` and a falling edge on `trig_p` have no effect.
- R8: A trigger level first sampled at clock edge k acts on the watchdog at edge k+2 (two-flop synchronizer plus edge register).
- R9: While `wd_off` or `low_pwr` is high, the watchdog is off. `rst_out_n` stays high once the power-on hold is over, and any running pulse is cut short. When both inputs return low, the lead-time phase starts again.
- R10: The power-on hold of R2 runs to completion whatever the state of `wd_off` and `low_pwr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication, high when the supply is in range |
| tick | input | 1 | One-clock timebase strobe; all intervals are counted in these |
| trig_n | input | 1 | Trigger pin, acts on its falling edge |
| trig_p | input | 1 | Trigger pin, acts on its rising edge |
| wd_off | input | 1 | High disables the watchdog |
| low_pwr | input | 1 | High while the system is in a sleep or silent mode; switches the watchdog off |
| rst_out_n | output | 1 | Active-low reset to the supervised controller |

## Verification
The output follows the phase register directly, so a change in `supply_ok`, `wd_off`, `low_pwr` or `tick` shows on `rst_out_n` one clock after it is sampled. A trigger level shows two clocks after it is first sampled, because of the synchronizer. The bench keeps a behavioural model with a three-deep history queue for each trigger pin and a tick counter for each phase. It compares the model's expected output with `rst_out_n` at every falling clock edge, half a cycle after the register has updated. Directed checks measure interval lengths in clocks against ranges derived from the tick spacing and sample the trigger latency exactly at edges k+1 and k+2.

// File: rtl/wdt_pkg.sv
// Package for the window watchdog: the phase encoding shared by the
// top module, its checker and anything that observes the phase.
package wdt_pkg;

    // Watchdog phases; reset is asserted in PH_HOLD and PH_PULSE only
    typedef enum logic [2:0] {
        PH_HOLD  = 3'd0,   // power-on hold, or supply not good
        PH_LEAD  = 3'd1,   // waiting for the first trigger
        PH_SHUT  = 3'd2,   // closed window, a trigger here is a fault
        PH_OPEN  = 3'd3,   // open window, a trigger here is expected
        PH_PULSE = 3'd4,   // watchdog reset pulse
        PH_IDLE  = 3'd5    // watchdog switched off
    } wdt_phase_e;

endpackage

// File: rtl/wdt_edge_sync.sv
// Synchronizes one asynchronous trigger pin and flags a single-cycle event
// when the synchronized level leaves its idle value.
// Assumes: the pin holds each level for at least two clocks.
module wdt_edge_sync #(
    parameter logic IDLE_LVL = 1'b1,
    parameter int   STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic evt
);
    logic [STAGES:0] pipe;

    // Shift the pin through the synchronizer stages plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {(STAGES+1){IDLE_LVL}};
        else        pipe <= {pipe[STAGES-1:0], pin};
    end

    // Event when the oldest sample was idle and the newer one is active
    assign evt = (pipe[STAGES] == IDLE_LVL) && (pipe[STAGES-1] != IDLE_LVL);
endmodule

// File: rtl/wdt_phase_timer.sv
// Counts timebase ticks inside the current phase. It reports expiry on the
// tick that completes `limit` ticks.
// Assumes: limit >= 1 and clear is raised on every phase change.
module wdt_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Restart on clear, otherwise advance by one on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (tick)       cnt <= cnt + CW'(1);
    end

    assign expired = tick && (cnt == limit - CW'(1));
endmodule

// File: rtl/wdt_supervisor.sv
// Window watchdog with power-on reset hold. It sequences the hold, lead,
// closed-window, open-window and pulse phases, and drives the active-low
// reset from the phase register.
// Assumes: tick is a one-clock strobe; supply_ok, wd_off and low_pwr are
// already synchronous to clk; trigger pins may be asynchronous.
module wdt_supervisor #(
    parameter int POR_TICKS   = 20,
    parameter int LEAD_TICKS  = 98,
    parameter int SHUT_TICKS  = 20,
    parameter int OPEN_TICKS  = 21,
    parameter int PULSE_TICKS = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic tick,
    input  logic trig_n,
    input  logic trig_p,
    input  logic wd_off,
    input  logic low_pwr,
    output logic rst_out_n
);
    import wdt_pkg::*;

    localparam int MAX_A = (POR_TICKS > LEAD_TICKS) ? POR_TICKS : LEAD_TICKS;
    localparam int MAX_B = (SHUT_TICKS > OPEN_TICKS) ? SHUT_TICKS : OPEN_TICKS;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXT  = (MAX_C > PULSE_TICKS) ? MAX_C : PULSE_TICKS;
    localparam int CW    = $clog2(MAXT + 1);
    localparam int NPIN  = 2;

    wdt_phase_e      phase, phase_nxt;
    logic [NPIN-1:0] pin_vec, evt_vec;
    logic            kick, off_req, tmr_clear, tmr_expired;
    logic [CW-1:0]   limit;

    assign pin_vec = {trig_p, trig_n};

    // One synchronizer per trigger pin; index 0 idles high, index 1 idles low
    for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
        wdt_edge_sync #(
            .IDLE_LVL ((gi == 0) ? 1'b1 : 1'b0),
            .STAGES   (SYNC_STAGES)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_vec[gi]),
            .evt   (evt_vec[gi])
        );
    end

    assign kick    = |evt_vec;
    assign off_req = wd_off | low_pwr;

    // Select the tick budget of the current phase
    always_comb begin
        case (phase)
            PH_HOLD:  limit = CW'(POR_TICKS);
            PH_LEAD:  limit = CW'(LEAD_TICKS);
            PH_SHUT:  limit = CW'(SHUT_TICKS);
            PH_OPEN:  limit = CW'(OPEN_TICKS);
            PH_PULSE: limit = CW'(PULSE_TICKS);
            default:  limit = CW'(MAXT);
        endcase
    end

    wdt_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .tick    (tick),
        .limit   (limit),
        .expired (tmr_expired)
    );

    // Phase sequencing: supply loss wins, then disable, then trigger, then expiry
    always_comb begin
        phase_nxt = phase;
        case (phase)
            PH_HOLD: if (tmr_expired) phase_nxt = off_req ? PH_IDLE : PH_LEAD;
            PH_IDLE: if (!off_req)    phase_nxt = PH_LEAD;
            default: begin
                if (off_req) begin
                    phase_nxt = PH_IDLE;
                end else begin
                    case (phase)
                        PH_LEAD:  if (kick) phase_nxt = PH_SHUT;
                                  else if (tmr_expired) phase_nxt = PH_PULSE;
                        PH_SHUT:  if (kick) phase_nxt = PH_PULSE;
                                  else if (tmr_expired) phase_nxt = PH_OPEN;
                        PH_OPEN:  if (kick) phase_nxt = PH_SHUT;
                                  else if (tmr_expired) phase_nxt = PH_PULSE;
                        PH_PULSE: if (tmr_expired) phase_nxt = PH_LEAD;
                        default:  phase_nxt = PH_HOLD;
                    endcase
                end
            end
        endcase
        if (!supply_ok) phase_nxt = PH_HOLD;
    end

    assign tmr_clear = (phase_nxt != phase) || !supply_ok;

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_HOLD;
        else        phase <= phase_nxt;
    end

    assign rst_out_n = !((phase == PH_HOLD) || (phase == PH_PULSE));
endmodule

// File: rtl/wdt_supervisor_chk.sv
// Temporal checks for wdt_supervisor, attached through bind below.
// Assumes: sampled on the block clock, disabled while rst_n is low.
module wdt_supervisor_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               supply_ok,
    input logic               tick,
    input logic               wd_off,
    input logic               low_pwr,
    input logic               rst_out_n,
    input logic               kick,
    input logic               expired,
    input wdt_pkg::wdt_phase_e phase
);
    import wdt_pkg::*;

    logic off_q;
    assign off_q = wd_off | low_pwr;

    // R1
    supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !rst_out_n);

    // R4
    early_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SHUT && kick && supply_ok && !off_q) |=> !rst_out_n);

    // R5
    open_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OPEN && kick && supply_ok && !off_q) |=> (rst_out_n && phase == PH_SHUT));

    // R3
    lead_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LEAD && expired && !kick && supply_ok && !off_q) |=> !rst_out_n);

    // R9
    off_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && off_q && rst_out_n) |=> rst_out_n);

    // R2
    release_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !off_q && !rst_out_n && !tick) |=> !rst_out_n);
endmodule

bind wdt_supervisor wdt_supervisor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .tick      (tick),
    .wd_off    (wd_off),
    .low_pwr   (low_pwr),
    .rst_out_n (rst_out_n),
    .kick      (kick),
    .expired   (tmr_expired),
    .phase     (phase)
);

// File: tb/wdt_supervisor_tb.sv
module wdt_supervisor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P_POR = 5, P_LEAD = 12, P_SHUT = 6, P_OPEN = 5, P_PULSE = 3;

    logic clk = 1'b0;
    logic rst_n, supply_ok, tick, trig_n, trig_p, wd_off, low_pwr, rst_out_n;
    int   checks = 0, fails = 0, tcnt = 0, n = 0, lows = 0;
    bit   mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_supervisor #(
        .POR_TICKS(P_POR), .LEAD_TICKS(P_LEAD), .SHUT_TICKS(P_SHUT),
        .OPEN_TICKS(P_OPEN), .PULSE_TICKS(P_PULSE), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .tick(tick),
        .trig_n(trig_n), .trig_p(trig_p), .wd_off(wd_off), .low_pwr(low_pwr),
        .rst_out_n(rst_out_n)
    );

    // Timebase: one strobe every fourth clock
    initial tick = 1'b0;
    always @(negedge clk) begin
        tick <= (tcnt == 3);
        tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    end

    // Behavioural reference: 0 hold,1 lead,2 closed,3 open,4 pulse,5 off
    int m_st = 0, m_cnt = 0;
    bit qn[$] = '{1'b1, 1'b1, 1'b1};
    bit qp[$] = '{1'b0, 1'b0, 1'b0};

    function automatic int budget(int s);
        case (s)
            0: return P_POR;
            1: return P_LEAD;
            2: return P_SHUT;
            3: return P_OPEN;
            4: return P_PULSE;
            default: return 1 << 20;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0;
            qn = '{1'b1, 1'b1, 1'b1};
            qp = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit trg, off, done;
            int nx;
            trg  = (qn[0] && !qn[1]) || (!qp[0] && qp[1]);
            off  = wd_off || low_pwr;
            done = tick && (m_cnt + 1 == budget(m_st));
            nx   = m_st;
            if (!supply_ok)                  nx = 0;
            else if (m_st == 0)              nx = done ? (off ? 5 : 1) : 0;
            else if (m_st == 5)              nx = off ? 5 : 1;
            else if (off)                    nx = 5;
            else if (m_st == 1 && trg)       nx = 2;
            else if (m_st == 1 && done)      nx = 4;
            else if (m_st == 2 && trg)       nx = 4;
            else if (m_st == 2 && done)      nx = 3;
            else if (m_st == 3 && trg)       nx = 2;
            else if (m_st == 3 && done)      nx = 4;
            else if (m_st == 4 && done)      nx = 1;
            if (nx != m_st || !supply_ok) m_cnt = 0;
            else if (tick)                m_cnt = m_cnt + 1;
            m_st = nx;
            qn.push_back(trig_n); void'(qn.pop_front());
            qp.push_back(trig_p); void'(qp.pop_front());
        end
    end

    // Compare the reference with the output half a cycle after each edge
    always @(negedge clk) begin
        if (mon_on) begin
            logic exp_o;
            exp_o = !(m_st == 0 || m_st == 4);
            checks++;
            if (rst_out_n !== exp_o) begin
                fails++;
                $display("FAIL %s (model phase %0d): rst_out_n=%b expected %b at %0t",
                         tag_of(m_st), m_st, rst_out_n, exp_o, $time);
            end
        end
    end

    task automatic expect_out(input logic exp_o, input string tag);
        checks++;
        if (rst_out_n !== exp_o) begin
            fails++;
            $display("FAIL %s: rst_out_n=%b expected %b at %0t", tag, rst_out_n, exp_o, $time);
        end
    endtask

    task automatic expect_range(input int v, input int lo, input int hi, input string tag);
        checks++;
        if (v < lo || v > hi) begin
            fails++;
            $display("FAIL %s: measured %0d clocks expected %0d..%0d", tag, v, lo, hi);
        end
    endtask

    task automatic wait_clk(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic clocks_until(input logic lvl, input int maxc, output int cnt);
        cnt = 0;
        while (rst_out_n !== lvl && cnt < maxc) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    task automatic kick_n();
        trig_n = 1'b0; wait_clk(3); trig_n = 1'b1;
    endtask

    task automatic kick_p();
        trig_p = 1'b1; wait_clk(3); trig_p = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog on the run itself
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; supply_ok = 1'b0; trig_n = 1'b1; trig_p = 1'b0;
        wd_off = 1'b0; low_pwr = 1'b0;
        wait_clk(4);
        expect_out(1'b0, "R1 reset state");
        rst_n = 1'b1; mon_on = 1'b1;
        wait_clk(3);
        expect_out(1'b0, "R1 supply low");

        // R2: power-on hold length
        supply_ok = 1'b1;
        clocks_until(1'b1, 40, n);
        expect_range(n, 16, 22, "R2 hold length");

        // R5: a run of good triggers, first one in the lead phase
        kick_n();
        for (int i = 0; i < 3; i++) begin
            wait_clk(31);
            kick_n();
        end
        expect_out(1'b1, "R5 good triggers");

        // R8 and R4: early trigger latency inside the closed window
        wait_clk(5);
        trig_n = 1'b0;
        @(negedge clk);
        expect_out(1'b1, "R8 edge k");
        @(negedge clk);
        expect_out(1'b1, "R8 edge k+1");
        @(negedge clk);
        expect_out(1'b0, "R8 R4 edge k+2");
        trig_n = 1'b1;

        // R6: pulse length, triggers ignored during it
        trig_p = 1'b1;
        clocks_until(1'b1, 30, n);
        expect_range(n + 1, 8, 13, "R6 pulse length");
        trig_p = 1'b0;

        // R3: lead timeout with no trigger
        clocks_until(1'b0, 80, n);
        expect_range(n, 44, 49, "R3 lead timeout");
        clocks_until(1'b1, 30, n);

        // R7: rising edge on trig_p is a trigger, then a missed open window
        kick_p();
        wait_clk(31);
        kick_p();
        expect_out(1'b1, "R7 trig_p accepted");
        clocks_until(1'b0, 80, n);
        expect_range(n + 3, 39, 47, "R5 open window expiry");
        clocks_until(1'b1, 30, n);

        // R7: falling edge on trig_p inside the closed window is ignored
        trig_p = 1'b1;
        wait_clk(6);
        trig_p = 1'b0;
        wait_clk(8);
        expect_out(1'b1, "R7 opposite edge ignored");
        clocks_until(1'b0, 80, n);
        clocks_until(1'b1, 30, n);

        // R9: disable input keeps reset high and blocks pulses
        wd_off = 1'b1;
        lows = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (rst_out_n !== 1'b1) lows++;
        end
        expect_range(lows, 0, 0, "R9 wd_off no reset");
        wd_off = 1'b0;
        clocks_until(1'b0, 80, n);
        expect_range(n, 44, 50, "R9 lead restart after enable");
        clocks_until(1'b1, 30, n);

        // R9: low-power mode, including cutting a running pulse short
        low_pwr = 1'b1;
        lows = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (rst_out_n !== 1'b1) lows++;
        end
        expect_range(lows, 0, 0, "R9 low_pwr no reset");
        low_pwr = 1'b0;
        clocks_until(1'b0, 80, n);
        wait_clk(2);
        low_pwr = 1'b1;
        wait_clk(2);
        expect_out(1'b1, "R9 pulse cut short");
        low_pwr = 1'b0;

        // R1 and R10: supply loss, then hold completes while disabled
        wait_clk(10);
        supply_ok = 1'b0;
        wait_clk(3);
        expect_out(1'b0, "R1 supply lost");
        wd_off = 1'b1;
        supply_ok = 1'b1;
        wait_clk(2);
        expect_out(1'b0, "R10 hold while disabled");
        clocks_until(1'b1, 40, n);
        expect_range(n + 2, 16, 22, "R10 hold length while disabled");
        wait_clk(60);
        expect_out(1'b1, "R9 off after hold");
        wd_off = 1'b0;
        wait_clk(10);
        finish_run();
    end
endmodule